// File: doc/BRIEF.md
# Serial Conversion Result Shifter

This block presents a 12-bit converter result on one serial data line. An external serial clock drives the transfer, and each transfer is a 16-bit frame: four zero bits come first, then the result in straight binary with the most significant bit first. The block counts the serial clock edges itself to know which frame bit to drive. When the sixteenth falling edge arrives it releases the line. The line's drive state appears on an explicit output-enable rather than on a tri-state net.

The serial clock is sampled in the block's own clock domain, and its rising and falling edges are detected there. Sometimes the controller sends clock pulses past a completed frame. The block then restarts from the first frame bit and keeps the line driven from that point on, even after the clock stops. Only a convert-start falling edge, taken while the serial clock is low, puts the counter back in step and releases the line. When a new result is loaded at the end of a conversion, any frame in progress is abandoned. The next rising edge then starts the new value from its first bit.

Top module: `serial_result_shifter`

## Requirements
- R1: After reset `sdata_oe` is 0 and `sdata` is 0.
- R2: A rising `sclk` edge while the line is released sets `sdata_oe` to 1 and drives frame bit 0, which is a zero.
- R3: Frame bit i (i = 0..15) is bit 15-i of the word {4'b0000, result}. Bit i for i >= 1 is launched on the i-th falling `sclk` edge, so bit i can be sampled during the (i+1)-th high phase of `sclk`.
- R4: On the 16th falling `sclk` edge of a normal frame, `sdata_oe` drops to 0.
- R5: A rising `sclk` edge after a completed frame starts the frame again from bit 0. From then on the 16th falling edge wraps back to bit 0 without dropping `sdata_oe`, and the line stays driven while `sclk` idles.
- R6: A `conv_fall` pulse while `sclk` is 0 clears the bit position, drops `sdata_oe` and clears the wrap state. The next frame starts at bit 0 and ends released.
- R7: A `conv_fall` pulse while `sclk` is 1 has no effect, and the frame in progress continues unchanged.
- R8: Holding `sclk` low for any length of time inside a frame keeps the bit position.
- R9: A `load` pulse captures `result_in` and drops `sdata_oe`. The next rising edge starts the new value from frame bit 0.
- R10: Whenever `sdata_oe` is 0, `sdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | External serial clock, idles low |
| conv_fall | input | 1 | One-cycle pulse marking a convert-start falling edge |
| load | input | 1 | One-cycle pulse that captures a new result |
| result_in | input | RES_W | Conversion result, straight binary |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | High while the data line is driven |

## Verification
The assertions assume three things about the inputs. `sclk` is already synchronous to `clk`. Each `sclk` level lasts at least one `clk` cycle, so no edge is lost. `conv_fall` and `load` are single-cycle pulses. The stimulus meets these by changing every input only on the falling edge of `clk` and by holding each `sclk` phase for two cycles. It pulses `conv_fall` both with `sclk` high and with `sclk` low, so that both the resynchronising case and the ignored case occur.

// File: rtl/serial_result_shifter.sv
module serial_result_shifter #(
  parameter int RES_W   = 12,
  parameter int FRAME_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             conv_fall,
  input  logic             load,
  input  logic [RES_W-1:0] result_in,
  output logic             sdata,
  output logic             sdata_oe
);
  localparam int PAD_W = FRAME_W - RES_W;
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [RES_W-1:0]   res_q;
  logic [CNT_W-1:0]   fcnt;
  logic               sclk_q, oe_q, sd_q, done_q, wrap_q;
  logic [FRAME_W-1:0] frame_w;
  logic               sclk_rise, sclk_fall, resync;

  assign frame_w   = {{PAD_W{1'b0}}, res_q};
  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign resync    = conv_fall & ~sclk;
  assign sdata     = sd_q;
  assign sdata_oe  = oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      fcnt   <= '0;
      sclk_q <= 1'b0;
      oe_q   <= 1'b0;
      sd_q   <= 1'b0;
      done_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (load) res_q <= result_in;
      if (load || resync) begin
        fcnt   <= '0;
        oe_q   <= 1'b0;
        sd_q   <= 1'b0;
        done_q <= 1'b0;
        wrap_q <= 1'b0;
      end else if (sclk_rise && !oe_q) begin
        oe_q   <= 1'b1;
        sd_q   <= frame_w[FRAME_W-1];
        wrap_q <= done_q;
        done_q <= 1'b0;
      end else if (sclk_fall && oe_q) begin
        if (fcnt == LAST) begin
          fcnt <= '0;
          if (wrap_q) begin
            sd_q <= frame_w[FRAME_W-1];
          end else begin
            oe_q   <= 1'b0;
            sd_q   <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          fcnt <= fcnt + 1'b1;
          sd_q <= frame_w[LAST - (fcnt + 1'b1)];
        end
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(!rst_n) |-> !sdata_oe && !sdata);

  // R10
  released_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !sdata_oe |-> !sdata);

  // R2
  enable_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(sclk) && !$past(sclk_q) && !sdata);

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe && (fcnt < CNT_W'(PAD_W)) |-> !sdata);

  // R6
  resync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fall && !sclk |=> !sdata_oe && fcnt == '0);

  // R5
  wrap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q && oe_q && sclk_fall && fcnt == LAST && !load && !resync |=> sdata_oe && fcnt == '0);

  // R8
  pause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk && !sclk_q && !load && !conv_fall |=> $stable(fcnt) && $stable(sdata) && $stable(sdata_oe));

  // R9
  load_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !sdata_oe && fcnt == '0);
endmodule

// File: tb/serial_result_shifter_tb.sv
module serial_result_shifter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic conv_fall = 1'b0;
  logic load = 1'b0;
  logic [11:0] result_in = '0;
  logic sdata, sdata_oe;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_result_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .conv_fall(conv_fall),
    .load(load), .result_in(result_in), .sdata(sdata), .sdata_oe(sdata_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [11:0] v);
    result_in = v; load = 1'b1; cyc(1); load = 1'b0; cyc(1);
  endtask

  task automatic do_conv();
    conv_fall = 1'b1; cyc(1); conv_fall = 1'b0; cyc(1);
  endtask

  // n clock pulses; bit sampled in each high phase; conv_fall pulsed in high phase conv_at
  task automatic read_bits(input int n, input int conv_at, inout logic [15:0] w, output bit oe_ok);
    oe_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; cyc(2);
      if (i == conv_at) do_conv();
      if (!sdata_oe) oe_ok = 1'b0;
      w = {w[14:0], sdata};
      sclk = 1'b0; cyc(2);
    end
  endtask

  task automatic t_reset();
    cyc(1);
    check("R1 oe", {15'd0, sdata_oe}, 16'd0);
    check("R1 sdata", {15'd0, sdata}, 16'd0);
  endtask

  task automatic t_basic();
    logic [15:0] w = '0; bit ok;
    do_load(12'hA5C);
    sclk = 1'b1; cyc(2);
    check("R2 first rise", {14'd0, sdata_oe, sdata}, 16'h0002);
    sclk = 1'b0; cyc(2);
    w = 16'd0;
    read_bits(15, -1, w, ok);
    check("R3 frame A5C", w, 16'h0A5C);
    check("R3 oe during frame", {15'd0, ok}, 16'd1);
    check("R4 released", {15'd0, sdata_oe}, 16'd0);
    check("R10 low when released", {15'd0, sdata}, 16'd0);
  endtask

  task automatic t_patterns();
    logic [11:0] pats [3] = '{12'hFFF, 12'h000, 12'h801};
    foreach (pats[k]) begin
      logic [15:0] w = '0; bit ok;
      do_load(pats[k]);
      read_bits(16, -1, w, ok);
      check("R3 pattern", w, {4'h0, pats[k]});
      check("R4 pattern end", {15'd0, sdata_oe}, 16'd0);
    end
  endtask

  task automatic t_overrun();
    logic [15:0] w = '0; bit ok;
    read_bits(16, -1, w, ok);
    check("R5 restart word", w, 16'h0801);
    check("R5 oe kept", {15'd0, sdata_oe}, 16'd1);
    cyc(60);
    check("R5 oe after idle", {15'd0, sdata_oe}, 16'd1);
    w = '0;
    read_bits(16, -1, w, ok);
    check("R5 second wrap", w, 16'h0801);
    do_conv();
    check("R6 resync release", {15'd0, sdata_oe}, 16'd0);
    w = '0;
    read_bits(16, -1, w, ok);
    check("R6 clean frame", w, 16'h0801);
    check("R6 end released", {15'd0, sdata_oe}, 16'd0);
  endtask

  task automatic t_conv_high();
    logic [15:0] w = '0; bit ok;
    do_conv();
    do_load(12'h3C6);
    read_bits(16, 6, w, ok);
    check("R7 frame intact", w, 16'h03C6);
    check("R7 oe stayed", {15'd0, ok}, 16'd1);
    check("R7 end released", {15'd0, sdata_oe}, 16'd0);
  endtask

  task automatic t_conv_low_mid();
    logic [15:0] w = '0; bit ok;
    read_bits(7, -1, w, ok);
    do_conv();
    check("R6 mid-frame release", {15'd0, sdata_oe}, 16'd0);
    w = '0;
    read_bits(16, -1, w, ok);
    check("R6 restart word", w, 16'h03C6);
  endtask

  task automatic t_pause();
    logic [15:0] w = '0; bit ok;
    read_bits(8, -1, w, ok);
    cyc(80);
    read_bits(8, -1, w, ok);
    check("R8 paused frame", w, 16'h03C6);
    check("R8 oe through pause", {15'd0, ok}, 16'd1);
  endtask

  task automatic t_load_mid();
    logic [15:0] w = '0; bit ok;
    read_bits(6, -1, w, ok);
    do_load(12'h5A3);
    check("R9 load release", {15'd0, sdata_oe}, 16'd0);
    w = '0;
    read_bits(16, -1, w, ok);
    check("R9 new value", w, 16'h05A3);
    check("R9 end released", {15'd0, sdata_oe}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_basic();
    t_patterns();
    t_overrun();
    t_conv_high();
    t_conv_low_mid();
    t_pause();
    t_load_mid();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule